// File: doc/BRIEF.md
# Limit Counter Timer with Sticky Reached Flag

This block is a memory-mapped counter/timer. A tick input marks each 500 ns period, and on every tick a 22-bit count field moves up by one. When the count reaches a programmed limit, the field goes back to zero. At that moment a sticky reached flag is set and a level interrupt is raised. A limit of zero selects free-running operation. In that case the field runs up to its full range and then wraps.

Software uses a 32-bit word-addressed register bus with one-cycle read and write strobes. The count is shown in bits 30..9 of the counter word, so bit 9 steps once per period. Bit 31 of the counter word carries the reached flag. Reading the limit word acknowledges the event: it clears both the flag and the interrupt. There are two ways to write the limit. One write address restarts the count from zero. A second write address replaces the limit and leaves the running count alone.

Top module: `lct_timer`

## Requirements
- R1: After reset, the limit word (offset 0) and the counter word (offset 1) both read as 0, and `irq` is low.
- R2: The counter word (offset 1) reads as {reached in bit 31, count in bits 30..9, zeros in bits 8..0}. Each `tick_en` pulse adds 0x200 to this word.
- R3: With a nonzero limit field L, the tick that would take the count to L sets it to 0 instead. The same tick sets the reached flag, and `irq` is high from the next cycle on. If that tick coincides with a read of the limit word, the new event wins and the flag and `irq` stay set.
- R4: A read of the limit word returns the limit as {0, field in bits 30..9, zeros in bits 8..0}. The read clears both the reached flag and `irq`.
- R5: A write to offset 0 stores bits 30..9 of the write data as the limit. It sets the count to 0 and drives `irq` low. The reached flag is left unchanged.
- R6: A write to offset 2 stores bits 30..9 of the write data as the limit. The count keeps its value.
- R7: A limit field of 0 means free-run: the count passes any value without setting the reached flag, until it wraps from 0x3FFFFE (word 0x7FFFFC00) to 0. That wrap sets the flag and `irq`.
- R8: If a write to offset 0 or 2 happens in the same cycle as a tick, the write takes effect and the tick is dropped.
- R9: Offset 3 (status) reads 1, because the counter always runs. Offset 4 (mode) reads 0. Offsets 5 to 7 read 0. Writes to offsets 3 to 7 change nothing, and a tick that coincides with such a write still counts.
- R10: The count holds while `tick_en` is low. The reached flag stays set across later ticks and wraps until the limit word is read.
- R11: `rdata` presents the word addressed by a `rd_en` cycle one clock later. The word reflects the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per 500 ns period |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
A wrong count or limit shows up in the counter word on the very next read. It also moves the cycle in which `irq` rises away from the tick that should complete the period, and the bench samples `irq` after every cycle, so that shift is caught. A flag that is not sticky, or that is cleared by the wrong access, changes bit 31 of the next counter read. The bench lines up ticks with writes and with limit reads in the same cycle, so that a wrong priority changes the count or the interrupt within one cycle.

// File: rtl/lct_pkg.sv
package lct_pkg;
  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_LIMIT  = 3'd0,
    OFS_COUNT  = 3'd1,
    OFS_LIMNR  = 3'd2,
    OFS_STATUS = 3'd3,
    OFS_MODE   = 3'd4
  } lct_ofs_e;
endpackage

// File: rtl/lct_decode.sv
module lct_decode
  import lct_pkg::*;
(
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  output logic             lim_wr,
  output logic             limnr_wr,
  output logic             lim_rd
);
  always_comb begin
    lim_wr   = wr_en && (addr == OFS_LIMIT);
    limnr_wr = wr_en && (addr == OFS_LIMNR);
    lim_rd   = rd_en && (addr == OFS_LIMIT);
  end
endmodule

// File: rtl/lct_counter.sv
module lct_counter #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             lim_wr,
  input  logic             limnr_wr,
  input  logic             lim_rd,
  input  logic [CNT_W-1:0] wr_field,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] lim,
  output logic             reached,
  output logic             irq
);
  localparam logic [CNT_W-1:0] FREE_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] eff_lim;
  logic [CNT_W:0]   cnt_inc;
  logic             any_wr;
  logic             step;
  logic             wrap;

  always_comb begin
    eff_lim = (lim == '0) ? FREE_TOP : lim;
    cnt_inc = {1'b0, cnt} + 1'b1;
    any_wr  = lim_wr || limnr_wr;
    step    = tick_en && !any_wr;
    wrap    = step && (cnt_inc >= {1'b0, eff_lim});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      lim     <= '0;
      reached <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (any_wr)
        lim <= wr_field;

      if (lim_wr)
        cnt <= '0;
      else if (wrap)
        cnt <= '0;
      else if (step)
        cnt <= cnt_inc[CNT_W-1:0];

      if (wrap)
        reached <= 1'b1;
      else if (lim_rd)
        reached <= 1'b0;

      if (wrap)
        irq <= 1'b1;
      else if (lim_rd || lim_wr)
        irq <= 1'b0;
    end
  end

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> reached); // R3
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(reached) |-> (cnt == '0)); // R3
  AST_LIMIT_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    lim_wr |=> (cnt == '0 && !irq)); // R5
  AST_NORESET_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
    limnr_wr |=> $stable(cnt)); // R6
  AST_LIMIT_READ_ACKS: assert property (@(posedge clk) disable iff (rst)
    (lim_rd && !tick_en) |=> (!reached && !irq)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !lim_wr) |=> $stable(cnt)); // R10
endmodule

// File: rtl/lct_rdmux.sv
module lct_rdmux
  import lct_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_LSB = 9,
  parameter int CNT_W   = DATA_W - 1 - CNT_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  lim,
  input  logic              reached,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word;

  always_comb begin
    word = '0;
    case (addr)
      OFS_LIMIT:  word = {1'b0, lim, {CNT_LSB{1'b0}}};
      OFS_COUNT:  word = {reached, cnt, {CNT_LSB{1'b0}}};
      OFS_STATUS: word = {{(DATA_W-1){1'b0}}, 1'b1};
      default:    word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= word;
  end

  AST_LIMIT_TOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == OFS_LIMIT) |=> !rdata[DATA_W-1]); // R4
endmodule

// File: rtl/lct_timer.sv
module lct_timer
  import lct_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_LSB = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int CNT_W = DATA_W - 1 - CNT_LSB;

  logic             lim_wr, limnr_wr, lim_rd;
  logic [CNT_W-1:0] cnt, lim;
  logic             reached;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[DATA_W-1], wdata[CNT_LSB-1:0]};

  lct_decode u_decode (
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .lim_wr   (lim_wr),
    .limnr_wr (limnr_wr),
    .lim_rd   (lim_rd)
  );

  lct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .lim_wr   (lim_wr),
    .limnr_wr (limnr_wr),
    .lim_rd   (lim_rd),
    .wr_field (wdata[DATA_W-2:CNT_LSB]),
    .cnt      (cnt),
    .lim      (lim),
    .reached  (reached),
    .irq      (irq)
  );

  lct_rdmux #(.DATA_W(DATA_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .addr    (addr),
    .cnt     (cnt),
    .lim     (lim),
    .reached (reached),
    .rdata   (rdata)
  );
endmodule

// File: tb/lct_timer_tb.sv
module lct_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        pend = 1'b0;

  logic [21:0] m_lim = '0, m_cnt = '0;
  bit          m_reached = 0, m_irq = 0;

  always #5 clk = ~clk;

  lct_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  always @(posedge clk) pend <= rd_en;

  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic step(input bit t, input bit w, input bit r,
                      input logic [2:0] a, input logic [31:0] d,
                      input string tag);
    logic [21:0] eff;
    logic [22:0] nxt;
    logic [31:0] e;
    bit hit, wrap;
    case (a)
      3'd0: e = {1'b0, m_lim, 9'b0};
      3'd1: e = {m_reached, m_cnt, 9'b0};
      3'd3: e = 32'd1;
      default: e = 32'd0;
    endcase
    if (r) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    tick_en = t; wr_en = w; rd_en = r; addr = a; wdata = d;
    eff  = (m_lim == 0) ? 22'h3FFFFF : m_lim;
    hit  = w && (a == 3'd0 || a == 3'd2);
    nxt  = {1'b0, m_cnt} + 23'd1;
    wrap = t && !hit && (nxt >= {1'b0, eff});
    if (r && a == 3'd0) begin m_reached = 0; m_irq = 0; end
    if (wrap) begin m_cnt = 0; m_reached = 1; m_irq = 1; end
    else if (t && !hit) m_cnt = nxt[21:0];
    if (w && a == 3'd0) begin m_lim = d[30:9]; m_cnt = 0; m_irq = 0; end
    if (w && a == 3'd2) m_lim = d[30:9];
    @(negedge clk);
    tick_en = 0; wr_en = 0; rd_en = 0;
    checks++;
    if (irq !== m_irq) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", tag, irq, m_irq);
    end
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 3'd0, 0, tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(0, 0, 1, a, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(3'd0, "R1 limit after reset");
    rd(3'd1, "R1 count after reset");
    // R2 count format and step
    ticks(5, "R2");
    rd(3'd1, "R2 count word");
    // R5 masked limit write clears count
    step(0, 1, 0, 3'd0, 32'h8000_09FF, "R5 limit write");
    rd(3'd1, "R5 count zero");
    rd(3'd0, "R4 limit readback masked");
    // R3 wrap at limit
    ticks(3, "R3");
    rd(3'd1, "R3 just before wrap");
    ticks(1, "R3 wrap tick");
    rd(3'd1, "R3 reached set, count zero");
    // R10 sticky flag across ticks
    ticks(6, "R10 sticky");
    rd(3'd1, "R10 flag still set");
    // R4 acknowledge
    rd(3'd0, "R4 limit read ack");
    rd(3'd1, "R4 flag cleared");
    // R3 wrap coincides with limit read
    ticks(1, "R3");
    step(1, 0, 1, 3'd0, 0, "R3 wrap wins over read");
    rd(3'd1, "R3 flag after coincident read");
    rd(3'd0, "R4 ack again");
    // R6 limit without reset
    ticks(2, "R6");
    step(0, 1, 0, 3'd2, 32'h0000_1400, "R6 norst write");
    rd(3'd1, "R6 count kept");
    ticks(8, "R6 run to new limit");
    rd(3'd1, "R6 wrap at new limit");
    rd(3'd0, "R4 ack");
    // R8 write beats coincident tick
    ticks(3, "R8");
    step(1, 1, 0, 3'd2, 32'h0000_1400, "R8 norst write with tick");
    rd(3'd1, "R8 tick dropped on norst write");
    step(1, 1, 0, 3'd0, 32'h0000_1400, "R8 limit write with tick");
    rd(3'd1, "R8 tick dropped on limit write");
    // R9 status, mode, undefined offsets
    step(1, 1, 0, 3'd3, 32'hFFFF_FFFF, "R9 status write");
    step(1, 1, 0, 3'd4, 32'hFFFF_FFFF, "R9 mode write");
    step(1, 1, 0, 3'd6, 32'hFFFF_FFFF, "R9 undefined write");
    rd(3'd1, "R9 ticks still counted");
    rd(3'd0, "R9 limit untouched");
    rd(3'd3, "R9 status");
    rd(3'd4, "R9 mode");
    rd(3'd5, "R9 offset 5");
    rd(3'd7, "R9 offset 7");
    // R10 no tick holds
    repeat (10) step(0, 0, 0, 3'd0, 0, "R10 idle");
    rd(3'd1, "R10 count held");
    // R7 free run
    step(0, 1, 0, 3'd0, 32'h0000_0000, "R7 free run select");
    ticks(40, "R7 free run");
    rd(3'd1, "R7 no flag, count 40");
    rd(3'd0, "R7 limit zero");
    // R11 latency: data comes from pre-edge state
    step(1, 0, 1, 3'd1, 0, "R11 read with tick sees old count");
    rd(3'd1, "R11 next read sees new count");
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule